// File: doc/BRIEF.md
# Peer-to-Peer Request Tag Remapper

This block sits between the ports of a multi-port PCI Express switch fabric and forwards requests from one port to another. Posted requests (writes and messages) cross unchanged. Non-posted requests keep their requester ID, which is the bus, device and function numbers. Their tag is swapped for one that the fabric owns, so no two outstanding requests leaving the fabric carry the same tag. The original tag and the source port are held in a pending table indexed by the new tag.

Completions come back carrying the fabric tag, possibly in a different order from the requests. The block looks up the entry by that tag alone and returns the original tag and the source port. It frees the entry in the same cycle. A completion whose tag names no pending entry is flagged and dropped. When every fabric tag is in use, non-posted requests are held off with `req_ready` while posted requests keep flowing. Both result paths are registered, so each result appears one clock after the input that caused it.

Top module: `p2p_tag_remap`

## Requirements
- R1: An accepted posted request (`req_posted`=1) appears on the request output one cycle later with `out_posted`=1. Its bus, device, function, tag and source port are unchanged.
- R2: An accepted non-posted request appears one cycle later with bus, device, function and source port unchanged. Its `out_tag` is the lowest-numbered free fabric tag, zero-extended to 8 bits.
- R3: A fabric tag is never handed out while an earlier request holding it still awaits its completion.
- R4: A completion whose `cpl_tag` (below 32) names a pending entry gives `cpl_out_valid`=1 one cycle later. `cpl_out_tag` carries the stored original tag and `cpl_out_port` the stored source port. This holds whatever order completions arrive in.
- R5: A matching completion frees its entry. The tag can be allocated again from the following cycle.
- R6: With all 32 tags pending, `req_ready` is 0 for a non-posted request and no request output follows. `req_ready` stays 1 for a posted request, which still passes.
- R7: A completion whose tag is 32 or above, or names a free entry, gives `cpl_unexp`=1 and `cpl_out_valid`=0 one cycle later. The table is left unchanged.
- R8: A tag freed by a completion in the same cycle that a non-posted request needs one is not reissued in that cycle. With the table full, `req_ready` stays 0 in that cycle.
- R9: After reset the table is empty, `req_ready`=1, and `out_valid`, `cpl_out_valid` and `cpl_unexp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_posted | input | 1 | 1 = posted, 0 = non-posted |
| req_bus | input | 8 | Requester bus number |
| req_dev | input | 5 | Requester device number |
| req_fn | input | 3 | Requester function number |
| req_tag | input | 8 | Requester tag |
| req_port | input | 3 | Source port |
| out_valid | output | 1 | Forwarded request valid |
| out_posted | output | 1 | Forwarded posted flag |
| out_bus | output | 8 | Forwarded bus number |
| out_dev | output | 5 | Forwarded device number |
| out_fn | output | 3 | Forwarded function number |
| out_tag | output | 8 | Forwarded tag (original or fabric) |
| out_port | output | 3 | Forwarded source port |
| cpl_valid | input | 1 | Completion present |
| cpl_tag | input | 8 | Fabric tag carried by the completion |
| cpl_out_valid | output | 1 | Restored completion valid |
| cpl_out_tag | output | 8 | Restored original tag |
| cpl_out_port | output | 3 | Port the completion returns to |
| cpl_unexp | output | 1 | Completion matched no pending entry |

## Verification
`req_ready` depends only on the current table state and `req_posted`. The bench reads it one time step after driving inputs, inside the same cycle. Forwarded requests, restored completions and the unexpected flag are each due exactly one clock after their stimulus. The bench drives on the falling edge and compares those outputs at the next falling edge. It takes the expected values from a reference table that it updates once per cycle, allocating before freeing, so a tag released in a cycle is never predicted for reuse in that same cycle.

// File: rtl/p2p_remap_pkg.sv
package p2p_remap_pkg;
   localparam int BUS_W = 8;
   localparam int DEV_W = 5;
   localparam int FN_W  = 3;

   typedef struct packed {
      logic [BUS_W-1:0] bus;
      logic [DEV_W-1:0] dev;
      logic [FN_W-1:0]  fn;
   } rid_t;
endpackage

// File: rtl/tag_pick.sv
module tag_pick #(
   parameter int N         = 32,
   parameter int IW        = 5,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [N-1:0]  busy,
   output logic [IW-1:0] idx,
   output logic          any_free
);
   initial begin
      assert (N <= (1 << IW)) else $error("tag_pick: IW too narrow for N");
   end

   assign any_free = ~&busy;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx = '0;
            for (int i = N - 1; i >= 0; i--)
               if (!busy[i]) idx = IW'(i);
         end
      end else begin : g_high
         always_comb begin
            idx = '0;
            for (int i = 0; i < N; i++)
               if (!busy[i]) idx = IW'(i);
         end
      end
   endgenerate
endmodule

// File: rtl/pend_table.sv
module pend_table #(
   parameter int DEPTH  = 32,
   parameter int TAG_W  = 5,
   parameter int OTAG_W = 8,
   parameter int PORT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [TAG_W-1:0]  alloc_idx,
   input  logic [OTAG_W-1:0] alloc_otag,
   input  logic [PORT_W-1:0] alloc_port,
   input  logic              cpl_valid,
   input  logic [OTAG_W-1:0] cpl_tag,
   output logic [DEPTH-1:0]  busy,
   output logic              hit,
   output logic [OTAG_W-1:0] hit_otag,
   output logic [PORT_W-1:0] hit_port
);
   initial begin
      assert (DEPTH == (1 << TAG_W)) else $error("pend_table: DEPTH must equal 2**TAG_W");
      assert (OTAG_W >= TAG_W) else $error("pend_table: OTAG_W below TAG_W");
   end

   logic [DEPTH-1:0]  busy_q;
   logic [OTAG_W-1:0] otag_q [DEPTH];
   logic [PORT_W-1:0] port_q [DEPTH];
   logic [TAG_W-1:0]  cpl_idx;
   logic              in_range;

   assign cpl_idx  = cpl_tag[TAG_W-1:0];
   assign in_range = (cpl_tag < OTAG_W'(DEPTH));
   assign hit      = cpl_valid & in_range & busy_q[cpl_idx];
   assign hit_otag = otag_q[cpl_idx];
   assign hit_port = port_q[cpl_idx];
   assign busy     = busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= '0;
      end else begin
         if (alloc_en) busy_q[alloc_idx] <= 1'b1;
         if (hit)      busy_q[cpl_idx]   <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (alloc_en) begin
         otag_q[alloc_idx] <= alloc_otag;
         port_q[alloc_idx] <= alloc_port;
      end
   end

   // R3
   no_double_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |-> !busy_q[alloc_idx]);
   // R5
   entry_freed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !busy_q[$past(cpl_idx)]);
   // R7
   unexp_keeps_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && !hit && !alloc_en) |=> busy_q == $past(busy_q));
   // R8
   no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && alloc_en) |-> alloc_idx != cpl_idx);
endmodule

// File: rtl/p2p_tag_remap.sv
module p2p_tag_remap
   import p2p_remap_pkg::*;
#(
   parameter int TAG_W  = 5,
   parameter int OTAG_W = 8,
   parameter int PORT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_posted,
   input  logic [BUS_W-1:0]  req_bus,
   input  logic [DEV_W-1:0]  req_dev,
   input  logic [FN_W-1:0]   req_fn,
   input  logic [OTAG_W-1:0] req_tag,
   input  logic [PORT_W-1:0] req_port,
   output logic              out_valid,
   output logic              out_posted,
   output logic [BUS_W-1:0]  out_bus,
   output logic [DEV_W-1:0]  out_dev,
   output logic [FN_W-1:0]   out_fn,
   output logic [OTAG_W-1:0] out_tag,
   output logic [PORT_W-1:0] out_port,
   input  logic              cpl_valid,
   input  logic [OTAG_W-1:0] cpl_tag,
   output logic              cpl_out_valid,
   output logic [OTAG_W-1:0] cpl_out_tag,
   output logic [PORT_W-1:0] cpl_out_port,
   output logic              cpl_unexp
);
   localparam int DEPTH = 1 << TAG_W;

   logic [DEPTH-1:0]  busy;
   logic [TAG_W-1:0]  pick_idx;
   logic              any_free;
   logic              accept, alloc_en;
   logic              hit;
   logic [OTAG_W-1:0] hit_otag;
   logic [PORT_W-1:0] hit_port;
   rid_t              rid_q;

   tag_pick #(.N(DEPTH), .IW(TAG_W), .LOW_FIRST(1'b1)) u_pick (
      .busy(busy), .idx(pick_idx), .any_free(any_free));

   pend_table #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OTAG_W(OTAG_W), .PORT_W(PORT_W)) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(alloc_en), .alloc_idx(pick_idx),
      .alloc_otag(req_tag), .alloc_port(req_port),
      .cpl_valid(cpl_valid), .cpl_tag(cpl_tag),
      .busy(busy), .hit(hit), .hit_otag(hit_otag), .hit_port(hit_port));

   assign req_ready = req_posted | any_free;
   assign accept    = req_valid & req_ready;
   assign alloc_en  = accept & ~req_posted;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         out_posted <= 1'b0;
         rid_q      <= '0;
         out_tag    <= '0;
         out_port   <= '0;
      end else begin
         out_valid  <= accept;
         out_posted <= req_posted;
         rid_q      <= '{bus: req_bus, dev: req_dev, fn: req_fn};
         out_tag    <= req_posted ? req_tag : OTAG_W'(pick_idx);
         out_port   <= req_port;
      end
   end

   assign out_bus = rid_q.bus;
   assign out_dev = rid_q.dev;
   assign out_fn  = rid_q.fn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpl_out_valid <= 1'b0;
         cpl_out_tag   <= '0;
         cpl_out_port  <= '0;
         cpl_unexp     <= 1'b0;
      end else begin
         cpl_out_valid <= hit;
         cpl_out_tag   <= hit_otag;
         cpl_out_port  <= hit_port;
         cpl_unexp     <= cpl_valid & ~hit;
      end
   end

   // R1
   posted_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_posted) |=> out_valid && out_posted && out_tag == $past(req_tag));
   // R6
   stall_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> !out_valid);
   // R4
   cpl_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpl_valid && hit) |=> cpl_out_valid && !cpl_unexp && cpl_out_tag == $past(hit_otag));
endmodule

// File: tb/sim_p2p_tag_remap.sv
module sim_p2p_tag_remap;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 0, req_posted = 0, cpl_valid = 0;
   logic [7:0] req_bus = 0, req_tag = 0, cpl_tag = 0;
   logic [4:0] req_dev = 0;
   logic [2:0] req_fn = 0, req_port = 0;
   logic req_ready, out_valid, out_posted, cpl_out_valid, cpl_unexp;
   logic [7:0] out_bus, out_tag, cpl_out_tag;
   logic [4:0] out_dev;
   logic [2:0] out_fn, out_port, cpl_out_port;

   int nchk = 0, nfail = 0, cyc = 0;
   bit busy_m [32];
   logic [7:0] otag_m [32];
   logic [2:0] port_m [32];

   always #2.5 clk = ~clk;

   p2p_tag_remap u0 (.*);

   task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0h exp=%0h", r, act, exp);
      end
   endtask

   function automatic int lowfree();
      for (int i = 0; i < 32; i++) if (!busy_m[i]) return i;
      return -1;
   endfunction

   task automatic step(input bit v, input bit p, input logic [7:0] b, input logic [4:0] d,
                       input logic [2:0] f, input logic [7:0] t, input logic [2:0] sp,
                       input bit cv, input logic [7:0] ct, input string lbl);
      int lf;
      bit rdy_e, acc, hit;
      logic [7:0] e_tag, e_ct;
      logic [2:0] e_cp;
      req_valid = v; req_posted = p; req_bus = b; req_dev = d; req_fn = f;
      req_tag = t; req_port = sp; cpl_valid = cv; cpl_tag = ct;
      #1;
      lf = lowfree();
      rdy_e = p || (lf >= 0);
      chk((lf < 0) ? "R6 ready" : "R9 ready", {31'd0, req_ready}, {31'd0, rdy_e});
      acc = v && rdy_e;
      e_tag = p ? t : lf[7:0];
      hit = cv && (ct < 8'd32) && busy_m[ct[4:0]];
      e_ct = otag_m[ct[4:0]];
      e_cp = port_m[ct[4:0]];
      if (acc && !p) begin
         chk("R3 fresh tag", {31'd0, busy_m[lf]}, 32'd0);
         busy_m[lf] = 1'b1; otag_m[lf] = t; port_m[lf] = sp;
      end
      if (hit) busy_m[ct[4:0]] = 1'b0;
      @(negedge clk);
      chk(lbl, {31'd0, out_valid}, {31'd0, acc});
      if (acc) begin
         chk(lbl, {out_posted, out_bus, out_dev, out_fn, out_port}, {p, b, d, f, sp});
         chk(p ? "R1 tag" : "R2 tag", {24'd0, out_tag}, {24'd0, e_tag});
      end
      chk(hit ? "R4 cpl" : "R7 cpl", {30'd0, cpl_out_valid, cpl_unexp}, {30'd0, hit, cv && !hit});
      if (hit) chk("R4 restore", {21'd0, cpl_out_tag, cpl_out_port}, {21'd0, e_ct, e_cp});
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         nfail++;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 32; i++) begin busy_m[i] = 0; otag_m[i] = 0; port_m[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R9 reset state
      chk("R9", {29'd0, req_ready, out_valid, cpl_out_valid}, {29'd0, 1'b1, 1'b0, 1'b0});
      chk("R9", {31'd0, cpl_unexp}, 32'd0);
      @(negedge clk);
      // R1 posted pass-through
      step(1, 1, 8'h3c, 5'd7, 3'd2, 8'hd5, 3'd4, 0, 8'd0, "R1");
      // R2 fill the table with non-posted requests
      for (int i = 0; i < 32; i++)
         step(1, 0, 8'(i + 1), 5'(i), 3'(i), 8'(8'hc0 + i), 3'(i), 0, 8'd0, "R2");
      // R6 full: non-posted stalls, posted still passes
      step(1, 0, 8'h11, 5'd1, 3'd1, 8'h99, 3'd5, 0, 8'd0, "R6");
      step(1, 1, 8'h22, 5'd2, 3'd3, 8'h77, 3'd6, 0, 8'd0, "R6");
      // R8 free and request in the same cycle: no reissue
      step(1, 0, 8'h33, 5'd3, 3'd4, 8'h55, 3'd1, 1, 8'd5, "R8");
      // R5 freed tag taken next cycle
      step(1, 0, 8'h33, 5'd3, 3'd4, 8'h55, 3'd1, 0, 8'd0, "R5");
      // R4 out-of-order completions
      step(0, 0, 8'd0, 5'd0, 3'd0, 8'd0, 3'd0, 1, 8'd20, "R4");
      step(0, 0, 8'd0, 5'd0, 3'd0, 8'd0, 3'd0, 1, 8'd3, "R4");
      step(0, 0, 8'd0, 5'd0, 3'd0, 8'd0, 3'd0, 1, 8'd31, "R4");
      // R7 unexpected: freed tag, then out-of-range tag
      step(0, 0, 8'd0, 5'd0, 3'd0, 8'd0, 3'd0, 1, 8'd3, "R7");
      step(0, 0, 8'd0, 5'd0, 3'd0, 8'd0, 3'd0, 1, 8'd200, "R7");
      // R7 table unchanged: allocation resumes at lowest free tag
      step(1, 0, 8'h44, 5'd9, 3'd0, 8'h0a, 3'd2, 0, 8'd0, "R7");
      // R3 random mix
      for (int n = 0; n < 3000; n++) begin
         logic [7:0] ct;
         int pick;
         pick = int'($urandom_range(0, 31));
         if ($urandom_range(0, 9) < 7 && busy_m[pick]) ct = 8'(pick);
         else ct = 8'($urandom_range(0, 40));
         step($urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
              8'($urandom), 5'($urandom), 3'($urandom), 8'($urandom), 3'($urandom),
              $urandom_range(0, 2) != 0, ct, "R3");
      end
      step(0, 0, 8'd0, 5'd0, 3'd0, 8'd0, 3'd0, 0, 8'd0, "R9");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule